// File: doc/BRIEF.md
# LED Fault Flag Combiner with Status Capture

This block collects the fault indications of a multi-channel LED sink driver and turns them into one shared, active-low error line. There are two fault sources. The first is a per-channel open-LED comparator. The second is an over-temperature sensor. The block drives an output-enable for an open-drain pull-down. When no fault is present it releases the line, so several drivers can share one pull-up resistor.

An open-LED fault only counts when three things hold: the channel's sink is switched on, the output is not blanked, and the comparator reports low output voltage. Because blanking removes all open-LED faults from the line, a host can raise blank and tell a thermal fault apart from an LED fault. The comparator bits arrive from another clock region, so each one passes through a two-flop synchronizer first. The thermal input is used as it arrives.

The block also keeps a status snapshot for later serial readout. On the trailing (falling) edge of the latch pulse it stores the qualified open-LED bits and the thermal bit.

Top module: `err_flag_agg`

## Requirements
- R1: While reset is high, at the next clock edge `err_oe` is 0, `stat_lod` is all zeros and `stat_tef` is 0.
- R2: With `tef_in` high, `err_oe` is 1 one clock after `tef_in` is sampled, whatever the values of `blank`, `lod_raw` and `chan_on`.
- R3: With `blank` low, `chan_on[n]` high and `lod_raw[n]` high, `err_oe` becomes 1 on the third clock edge after `lod_raw[n]` rises (two synchronizer stages plus the output register), and it is still 0 after the second edge.
- R4: With `blank` high and `tef_in` low, `err_oe` is 0 whatever the values of `lod_raw` and `chan_on`.
- R5: A high `lod_raw[n]` while `chan_on[n]` is low has no effect on `err_oe` or on `stat_lod[n]`.
- R6: On the clock edge where `latch` is sampled low after having been sampled high on the previous edge, `stat_lod` loads the qualified flags `sync(lod_raw) & chan_on`. Bit n of `stat_lod` belongs to channel n.
- R7: `stat_lod` and `stat_tef` keep their values on every other edge, including the edge where `latch` rises and the edges while it stays high.
- R8: `stat_tef` loads `tef_in` on the same falling-latch edge that loads `stat_lod`.
- R9: When `tef_in` falls and no unmasked open-LED flag is active, `err_oe` returns to 0 one clock later.
- R10: Status capture is not masked by `blank`: a qualified open-LED flag is stored even while `blank` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lod_raw | input | NUM_CH | Per-channel open-LED comparator outputs, asynchronous |
| chan_on | input | NUM_CH | Per-channel sink-on enables |
| tef_in | input | 1 | Over-temperature indication |
| blank | input | 1 | Output blanking; masks open-LED faults from the error line |
| latch | input | 1 | Latch pulse; status is captured on its falling edge |
| err_oe | output | 1 | Pull-down enable for the shared open-drain error line (1 = pull low) |
| stat_lod | output | NUM_CH | Captured open-LED status, bit n = channel n |
| stat_tef | output | 1 | Captured over-temperature status |

## Verification
Suppose a synchronizer stage is missing or extra, or the output register is bypassed. Then an open-LED fault reaches `err_oe` one edge early or late, and the check at exactly the third edge exposes it. A wrong latch-edge detector state shows at the status ports within one edge of the latch pulse. If it captures on the rising edge, or fails to hold, the status ports change while `latch` is still high or hold stale bits after it falls. A broken mask term shows one edge after the inputs settle: `err_oe` is driven while only blanked or unpowered channels report a fault.

// File: rtl/err_pkg.sv
package err_pkg;

    localparam int N_CH_DEF    = 16;
    localparam int SYNC_STAGES = 2;

    // Snapshot held for serial readout
    typedef struct packed {
        logic                tef;
        logic [N_CH_DEF-1:0] lod;
    } status_t;

    // Pull-down demand for the shared error line
    function automatic logic err_demand(input logic tef, input logic blank,
                                        input logic any_lod);
        return tef | (any_lod & ~blank);
    endfunction

endpackage

// File: rtl/err_sync.sv
module err_sync #(
    parameter int WIDTH  = 16,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);
    logic [WIDTH-1:0] chain [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= '0;
                    else     chain[0] <= d_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= '0;
                    else     chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign d_out = chain[STAGES-1];
endmodule

// File: rtl/err_combine.sv
module err_combine #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] lod_q,
    input  logic             tef_in,
    input  logic             blank,
    output logic             err_oe
);
    import err_pkg::*;

    logic demand;

    always_comb begin
        demand = err_demand(tef_in, blank, |lod_q);
    end

    always_ff @(posedge clk) begin
        if (rst) err_oe <= 1'b0;
        else     err_oe <= demand;
    end
endmodule

// File: rtl/err_capture.sv
module err_capture #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             latch,
    input  logic [WIDTH-1:0] lod_q,
    input  logic             tef_in,
    output logic [WIDTH-1:0] stat_lod,
    output logic             stat_tef
);
    logic latch_d;
    logic trail;

    always_ff @(posedge clk) begin
        if (rst) latch_d <= 1'b0;
        else     latch_d <= latch;
    end

    assign trail = latch_d & ~latch;

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_lod <= '0;
            stat_tef <= 1'b0;
        end else if (trail) begin
            stat_lod <= lod_q;
            stat_tef <= tef_in;
        end
    end
endmodule

// File: rtl/err_flag_agg.sv
module err_flag_agg #(
    parameter int NUM_CH = err_pkg::N_CH_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] lod_raw,
    input  logic [NUM_CH-1:0] chan_on,
    input  logic              tef_in,
    input  logic              blank,
    input  logic              latch,
    output logic              err_oe,
    output logic [NUM_CH-1:0] stat_lod,
    output logic              stat_tef
);
    logic [NUM_CH-1:0] lod_sync;
    logic [NUM_CH-1:0] lod_qual;

    err_sync #(.WIDTH(NUM_CH), .STAGES(err_pkg::SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .d_in  (lod_raw),
        .d_out (lod_sync)
    );

    // A flag only counts while its sink is switched on
    assign lod_qual = lod_sync & chan_on;

    err_combine #(.WIDTH(NUM_CH)) u_comb (
        .clk    (clk),
        .rst    (rst),
        .lod_q  (lod_qual),
        .tef_in (tef_in),
        .blank  (blank),
        .err_oe (err_oe)
    );

    err_capture #(.WIDTH(NUM_CH)) u_cap (
        .clk      (clk),
        .rst      (rst),
        .latch    (latch),
        .lod_q    (lod_qual),
        .tef_in   (tef_in),
        .stat_lod (stat_lod),
        .stat_tef (stat_tef)
    );
endmodule

// File: rtl/err_flag_agg_chk.sv
module err_flag_agg_chk #(
    parameter int NUM_CH = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              tef_in,
    input logic              blank,
    input logic              latch,
    input logic              err_oe,
    input logic [NUM_CH-1:0] stat_lod,
    input logic              stat_tef
);
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!err_oe && stat_lod == '0 && !stat_tef));

    p_tef_drives_r2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(tef_in)) |-> err_oe);

    p_blank_masks_r4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(blank) && !$past(tef_in)) |-> !err_oe);

    p_hold_status_r7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !($past(latch, 2) && !$past(latch)))
            |-> ($stable(stat_lod) && $stable(stat_tef)));

    p_tef_capture_r8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2) && $past(latch, 2) && !$past(latch))
            |-> (stat_tef == $past(tef_in)));
endmodule

bind err_flag_agg err_flag_agg_chk #(.NUM_CH(NUM_CH)) u_err_chk (
    .clk      (clk),
    .rst      (rst),
    .tef_in   (tef_in),
    .blank    (blank),
    .latch    (latch),
    .err_oe   (err_oe),
    .stat_lod (stat_lod),
    .stat_tef (stat_tef)
);

// File: tb/test_err_flag_agg.sv
module test_err_flag_agg;
    localparam int CLK_PERIOD = 10;
    localparam int N = 16;
    localparam int NVEC = 8;

    // fields: [34] tef, [33] blank, [32:17] lod_raw, [16:1] chan_on, [0] expected err_oe
    localparam logic [34:0] VEC [NVEC] = '{
        {1'b0, 1'b0, 16'h0000, 16'hFFFF, 1'b0},
        {1'b1, 1'b1, 16'h0000, 16'h0000, 1'b1},
        {1'b0, 1'b0, 16'h0010, 16'h0010, 1'b1},
        {1'b0, 1'b1, 16'hFFFF, 16'hFFFF, 1'b0},
        {1'b0, 1'b0, 16'h00F0, 16'h0F0F, 1'b0},
        {1'b1, 1'b0, 16'h8000, 16'h8000, 1'b1},
        {1'b0, 1'b0, 16'h8001, 16'h0001, 1'b1},
        {1'b1, 1'b1, 16'hFFFF, 16'hFFFF, 1'b1}
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] lod_raw = '0;
    logic [N-1:0] chan_on = '0;
    logic         tef_in = 1'b0;
    logic         blank = 1'b0;
    logic         latch = 1'b0;
    logic         err_oe;
    logic [N-1:0] stat_lod;
    logic         stat_tef;

    int n_run  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    err_flag_agg #(.NUM_CH(N)) i_err_flag_agg (
        .clk(clk), .rst(rst), .lod_raw(lod_raw), .chan_on(chan_on),
        .tef_in(tef_in), .blank(blank), .latch(latch),
        .err_oe(err_oe), .stat_lod(stat_lod), .stat_tef(stat_tef)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int k);
        repeat (k) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        // R1 reset state
        tef_in = 1'b1; lod_raw = '1; chan_on = '1; latch = 1'b1;
        cyc(3);
        check("R1 err_oe", {31'd0, err_oe}, 32'd0);
        check("R1 stat_lod", {16'd0, stat_lod}, 32'd0);
        check("R1 stat_tef", {31'd0, stat_tef}, 32'd0);
        tef_in = 1'b0; lod_raw = '0; chan_on = '0; latch = 1'b0;
        cyc(1);
        rst = 1'b0;
        cyc(4);

        // table: R2 R3 R4 R5 combinations on err_oe
        for (int i = 0; i < NVEC; i++) begin
            tef_in  = VEC[i][34];
            blank   = VEC[i][33];
            lod_raw = VEC[i][32:17];
            chan_on = VEC[i][16:1];
            cyc(4);
            check($sformatf("R2/R3/R4/R5 vector %0d", i), {31'd0, err_oe}, {31'd0, VEC[i][0]});
        end

        // clear
        tef_in = 1'b0; blank = 1'b0; lod_raw = '0; chan_on = '0;
        cyc(4);

        // R3 exact latency
        chan_on = 16'h0004;
        lod_raw = 16'h0004;
        cyc(2);
        check("R3 not yet after 2 edges", {31'd0, err_oe}, 32'd0);
        cyc(1);
        check("R3 asserted after 3 edges", {31'd0, err_oe}, 32'd1);
        lod_raw = '0; chan_on = '0;
        cyc(4);

        // R9 tef release after one edge
        tef_in = 1'b1;
        cyc(1);
        check("R2 tef asserts in one edge", {31'd0, err_oe}, 32'd1);
        tef_in = 1'b0;
        cyc(1);
        check("R9 tef release in one edge", {31'd0, err_oe}, 32'd0);

        // R6 R7 R8 capture on trailing edge
        lod_raw = 16'hA5C3; chan_on = 16'hFF0F; tef_in = 1'b1;
        cyc(4);
        latch = 1'b1;
        cyc(1);
        check("R7 no capture on rising latch", {16'd0, stat_lod}, 32'd0);
        cyc(2);
        check("R7 no capture while latch high", {31'd0, stat_tef}, 32'd0);
        latch = 1'b0;
        cyc(1);
        check("R6 capture on falling latch", {16'd0, stat_lod}, {16'd0, 16'hA5C3 & 16'hFF0F});
        check("R8 tef captured", {31'd0, stat_tef}, 32'd1);
        check("R5 unpowered channel bit 4 not captured", {31'd0, stat_lod[4]}, 32'd0);

        // R7 hold when inputs change without latch
        lod_raw = 16'h0000; tef_in = 1'b0;
        cyc(5);
        check("R7 status held", {15'd0, stat_tef, stat_lod}, {15'd0, 1'b1, 16'hA5C3 & 16'hFF0F});

        // R10 capture while blanked
        blank = 1'b1; lod_raw = 16'h0101; chan_on = 16'h0001;
        cyc(4);
        check("R4 blanked line released", {31'd0, err_oe}, 32'd0);
        latch = 1'b1;
        cyc(1);
        latch = 1'b0;
        cyc(1);
        check("R10 capture under blank", {16'd0, stat_lod}, 32'h0001);
        check("R8 tef low captured", {31'd0, stat_tef}, 32'd0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule